// File: doc/BRIEF.md
# Latched BCD Seven-Segment Decoder

This block turns a four-bit binary-coded-decimal digit into seven active-high segment drives for a common-cathode display. A hold register sits between the digit input and the decoder. While the store control is low, the register takes a new digit on every rising clock edge. While store is high, the register keeps its value, so the displayed digit stays fixed whatever the input does. The six codes above nine have no decimal meaning, and the decoder shows them as a dark digit.

Two active-low overrides act on the output path only. Lamp-test turns on every segment so a faulty segment can be spotted. Blanking turns every segment off. Lamp-test wins over blanking, and both win over the decoded digit. Neither override touches the held digit. Segment bits are packed as `{g,f,e,d,c,b,a}`, so bit 0 is segment a and bit 6 is segment g.

Top module: `segdec_top`

## Requirements
- R1: When reset is high at a rising edge, the held digit becomes 0. With both overrides released, `seg` then reads 7'h3F.
- R2: With both overrides high, held digits 0 to 9 drive `seg` = 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex, bit 0 = a, bit 6 = g).
- R3: With both overrides high, a held code from 10 to 15 drives `seg` to 7'h00.
- R4: While `store` is low, the held digit takes `bcd_in` at each rising edge. `seg` shows the new digit after that edge.
- R5: While `store` is high, the held digit does not change, and `seg` ignores any change on `bcd_in`.
- R6: While `lamp_test_n` is low, `seg` is 7'h7F in the same cycle, whatever the held digit is.
- R7: While `blank_n` is low and `lamp_test_n` is high, `seg` is 7'h00 in the same cycle.
- R8: When both `lamp_test_n` and `blank_n` are low, `seg` is 7'h7F, because lamp-test has priority.
- R9: Lamp-test and blanking leave the held digit as it is. Once both are released, `seg` shows the digit that was held before them. Loading under `store` low also continues while an override is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the hold register |
| rst | input | 1 | Synchronous active-high reset; clears the held digit |
| bcd_in | input | 4 | BCD digit to be shown |
| lamp_test_n | input | 1 | Active-low lamp-test; turns all segments on |
| blank_n | input | 1 | Active-low blanking; turns all segments off |
| store | input | 1 | High keeps the held digit; low loads it each edge |
| seg | output | 7 | Segment drives `{g,f,e,d,c,b,a}`, active high |

## Verification
A change on `bcd_in` reaches `seg` one rising edge after it is applied, because the hold register is the only register on that path. The overrides have no register on their path, so they act in the same cycle. The bench changes inputs on the falling edge. It checks digit results at the next falling edge, after exactly one rising edge has passed. It checks override results a short delay after the inputs change, before any rising edge, so a wrong extra register on the override path would show up as a wrong value.

// File: rtl/segdec_pkg.sv
package segdec_pkg;

    localparam int BCD_W  = 4;
    localparam int SEG_W  = 7;
    localparam int MAX_DIGIT = 9;

    typedef logic [BCD_W-1:0] bcd_t;
    typedef logic [SEG_W-1:0] seg_t;

    localparam seg_t SEG_ALL_ON  = '1;
    localparam seg_t SEG_ALL_OFF = '0;

    typedef enum logic [1:0] {
        DRV_DIGIT  = 2'd0,
        DRV_ALL_ON = 2'd1,
        DRV_DARK   = 2'd2
    } drive_mode_e;

    typedef struct packed {
        logic lamp_req;
        logic dark_req;
    } ovr_t;

    // Segment pattern for one digit, bit 0 = segment a.
    function automatic seg_t digit_pattern(input bcd_t d);
        seg_t p;
        case (d)
            4'd0: p = 7'h3F;
            4'd1: p = 7'h06;
            4'd2: p = 7'h5B;
            4'd3: p = 7'h4F;
            4'd4: p = 7'h66;
            4'd5: p = 7'h6D;
            4'd6: p = 7'h7D;
            4'd7: p = 7'h07;
            4'd8: p = 7'h7F;
            4'd9: p = 7'h6F;
            default: p = SEG_ALL_OFF;
        endcase
        return p;
    endfunction

    function automatic drive_mode_e pick_mode(input ovr_t o);
        if (o.lamp_req)      return DRV_ALL_ON;
        else if (o.dark_req) return DRV_DARK;
        else                 return DRV_DIGIT;
    endfunction

endpackage

// File: rtl/segdec_hold.sv
module segdec_hold #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/segdec_lut.sv
module segdec_lut
    import segdec_pkg::*;
(
    input  bcd_t digit,
    output seg_t pattern,
    output logic valid
);
    always_comb begin
        valid   = (int'(digit) <= MAX_DIGIT);
        pattern = valid ? digit_pattern(digit) : SEG_ALL_OFF;
    end
endmodule

// File: rtl/segdec_drive.sv
module segdec_drive
    import segdec_pkg::*;
(
    input  ovr_t ovr,
    input  seg_t pattern,
    output seg_t seg
);
    drive_mode_e mode;

    always_comb begin
        mode = pick_mode(ovr);
        case (mode)
            DRV_ALL_ON: seg = SEG_ALL_ON;
            DRV_DARK:   seg = SEG_ALL_OFF;
            default:    seg = pattern;
        endcase
    end
endmodule

// File: rtl/segdec_top.sv
module segdec_top
    import segdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [BCD_W-1:0] bcd_in,
    input  logic             lamp_test_n,
    input  logic             blank_n,
    input  logic             store,
    output logic [SEG_W-1:0] seg
);
    bcd_t held_q;
    seg_t pattern;
    logic digit_ok;
    ovr_t ovr;

    segdec_hold #(.W(BCD_W)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (!store),
        .d    (bcd_in),
        .q    (held_q)
    );

    segdec_lut u_lut (
        .digit   (held_q),
        .pattern (pattern),
        .valid   (digit_ok)
    );

    assign ovr.lamp_req = !lamp_test_n;
    assign ovr.dark_req = !blank_n;

    segdec_drive u_drive (
        .ovr     (ovr),
        .pattern (pattern),
        .seg     (seg)
    );
endmodule

// File: rtl/segdec_chk.sv
module segdec_chk
    import segdec_pkg::*;
(
    input logic clk,
    input logic rst,
    input bcd_t bcd_in,
    input logic lamp_test_n,
    input logic blank_n,
    input logic store,
    input bcd_t held_q,
    input logic digit_ok,
    input seg_t seg
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> held_q == '0);

    assert_bad_code_dark_R3: assert property (@(posedge clk) disable iff (rst)
        (lamp_test_n && blank_n && !digit_ok) |-> seg == SEG_ALL_OFF);

    assert_load_follows_R4: assert property (@(posedge clk) disable iff (rst)
        !store |=> held_q == $past(bcd_in));

    assert_store_freezes_R5: assert property (@(posedge clk) disable iff (rst)
        store |=> $stable(held_q));

    assert_lamp_all_on_R6: assert property (@(posedge clk) disable iff (rst)
        !lamp_test_n |-> seg == SEG_ALL_ON);

    assert_blank_dark_R7: assert property (@(posedge clk) disable iff (rst)
        (lamp_test_n && !blank_n) |-> seg == SEG_ALL_OFF);

    assert_override_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        (store && (!lamp_test_n || !blank_n)) |=> $stable(held_q));
endmodule

bind segdec_top segdec_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bcd_in      (bcd_in),
    .lamp_test_n (lamp_test_n),
    .blank_n     (blank_n),
    .store       (store),
    .held_q      (held_q),
    .digit_ok    (digit_ok),
    .seg         (seg)
);

// File: tb/sim_segdec_top.sv
module sim_segdec_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] bcd_in;
    logic       lamp_test_n;
    logic       blank_n;
    logic       store;
    logic [6:0] seg;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    segdec_top u0 (
        .clk(clk), .rst(rst), .bcd_in(bcd_in),
        .lamp_test_n(lamp_test_n), .blank_n(blank_n),
        .store(store), .seg(seg)
    );

    function automatic logic [6:0] want(input int d);
        case (d)
            0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;
            3: return 7'h4F;  4: return 7'h66;  5: return 7'h6D;
            6: return 7'h7D;  7: return 7'h07;  8: return 7'h7F;
            9: return 7'h6F;  default: return 7'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: seg act=%h exp=%h", req, act, exp);
        end
    endtask

    // drive at falling edge, let one rising edge pass, sample at next falling edge
    task automatic load_digit(input logic [3:0] d);
        bcd_in = d;
        store  = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1; store = 1'b1; bcd_in = 4'd7;
        lamp_test_n = 1'b1; blank_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1", seg, 7'h3F);
        rst = 1'b0;
    endtask

    task automatic t_digits;
        for (int d = 0; d < 10; d++) begin
            load_digit(4'(d));
            chk("R2", seg, want(d));
        end
    endtask

    task automatic t_bad_codes;
        for (int d = 10; d < 16; d++) begin
            load_digit(4'(d));
            chk("R3", seg, 7'h00);
        end
    endtask

    task automatic t_follow;
        load_digit(4'd3);
        bcd_in = 4'd6;
        #1 chk("R4", seg, want(3));
        @(posedge clk); @(negedge clk);
        chk("R4", seg, want(6));
    endtask

    task automatic t_store;
        load_digit(4'd4);
        store = 1'b1;
        for (int d = 0; d < 16; d++) begin
            bcd_in = 4'(d);
            @(posedge clk); @(negedge clk);
            chk("R5", seg, want(4));
        end
        store = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R5", seg, 7'h00);
    endtask

    task automatic t_lamp;
        load_digit(4'd1);
        lamp_test_n = 1'b0;
        #1 chk("R6", seg, 7'h7F);
        load_digit(4'd12);
        chk("R6", seg, 7'h7F);
        lamp_test_n = 1'b1;
        #1 chk("R6", seg, 7'h00);
    endtask

    task automatic t_blank;
        load_digit(4'd8);
        blank_n = 1'b0;
        #1 chk("R7", seg, 7'h00);
        load_digit(4'd0);
        chk("R7", seg, 7'h00);
        blank_n = 1'b1;
        #1 chk("R7", seg, want(0));
    endtask

    task automatic t_priority;
        load_digit(4'd2);
        lamp_test_n = 1'b0; blank_n = 1'b0;
        #1 chk("R8", seg, 7'h7F);
        lamp_test_n = 1'b1;
        #1 chk("R8", seg, 7'h00);
        blank_n = 1'b1;
        #1 chk("R8", seg, want(2));
    endtask

    task automatic t_preserve;
        load_digit(4'd5);
        store = 1'b1; bcd_in = 4'd9;
        lamp_test_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        lamp_test_n = 1'b1;
        #1 chk("R9", seg, want(5));
        blank_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        blank_n = 1'b1;
        #1 chk("R9", seg, want(5));
        lamp_test_n = 1'b0;
        load_digit(4'd9);
        lamp_test_n = 1'b1;
        #1 chk("R9", seg, want(9));
    endtask

    initial begin
        t_reset();
        t_digits();
        t_bad_codes();
        t_follow();
        t_store();
        t_lamp();
        t_blank();
        t_priority();
        t_preserve();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule